// File: doc/BRIEF.md
# Blanked Dual-Output PWM Generator

A fixed-frequency digital pulse-width modulator built around a free-running counter. Each period opens with a dead-time interval. During it the clock-out pin is high, both drive outputs are held low, and this interval sets the largest possible duty cycle. When the clock-out falls, the selected output or outputs go high. The pulse then ends at the first of three events: the ramp reaches the duty command, the cycle-by-cycle current-limit flag asserts, or the overcurrent flag asserts.

For a programmable number of cycles after the pulse begins, the ramp crossing and the current-limit flag are ignored. This keeps switching noise from cutting the pulse short. The overcurrent flag is never masked and removes the outputs in the same cycle. The ramp is either the internal count since the pulse started or an external sense word. An external soft-start clamp limits the duty command. In alternating mode the two outputs take turns from one period to the next. In in-phase mode both outputs switch together every period.

Period length, dead-time length, blanking length, output mode and ramp source are all sampled at period boundaries, so a pulse already in progress is never disturbed. A force-low input from the fault or supply-monitor logic overrides everything.

Top module: `blanked_pwm`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, out_a_o and out_b_o are low, clk_o is high, and the configuration takes its parameter defaults (period 20, dead time 3, blanking 2, in-phase mode, internal ramp).
- R2: Each period lasts P cycles. clk_o is high for the first D cycles of it, and both outputs are low whenever clk_o is high. Loaded values are clamped: P is at least 2, and D lies in the range 1 to P-1.
- R3: A pulse can begin only on the first cycle of a period in which clk_o is low, and never later in that period.
- R4: With the internal ramp, the ramp value equals the number of cycles since pulse start, counting the start cycle as 1. An unblanked pulse stays high for exactly E cycles, where E is the effective duty, or until the period ends, whichever comes first.
- R5: If ilim_i is high in a cycle of the pulse that lies outside blanking, the outputs go low in the next cycle and stay low until the next period.
- R6: During the first B cycles of a pulse (B being the blanking length), the ramp crossing and ilim_i have no effect. The minimum pulse is therefore B cycles, or 1 cycle when B is 0.
- R7: oc_i high drives both outputs low in the same cycle, whether or not blanking is active, and the pulse does not resume in that period.
- R8: If the effective duty is at or below ZERO_FLOOR (default 1), no pulse is produced.
- R9: The effective duty is the smaller of duty_i and ss_clamp_i.
- R10: mode_i value 1 selects alternating mode. The first period after reset drives out_a_o, and each later period in alternating mode moves to the other output. The two outputs are never high together in this mode. Value 0 selects in-phase mode, in which both outputs carry the same pulse.
- R11: force_low_i high drives both outputs low in the same cycle, and the pulse does not resume in that period.
- R12: per_i, dead_i, blank_i, mode_i and ramp_sel_i are taken only on the last cycle of a period and apply from the next period onward.
- R13: ramp_sel_i value 1 selects the external ramp. In that mode an unblanked crossing occurs in any pulse cycle where sense_i is greater than or equal to the effective duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| per_i | input | CNT_W | Period length in cycles |
| dead_i | input | CNT_W | Dead-time length in cycles |
| blank_i | input | CNT_W | Blanking length in cycles |
| mode_i | input | 1 | 0 in-phase, 1 alternating |
| ramp_sel_i | input | 1 | 0 internal ramp, 1 external sense |
| duty_i | input | CNT_W | Duty command |
| ss_clamp_i | input | CNT_W | Soft-start clamp on the duty command |
| sense_i | input | CNT_W | External ramp or sense value |
| ilim_i | input | 1 | Cycle-by-cycle current-limit flag |
| oc_i | input | 1 | Overcurrent flag, never blanked |
| force_low_i | input | 1 | Force both outputs low |
| out_a_o | output | 1 | Drive output A |
| out_b_o | output | 1 | Drive output B |
| clk_o | output | 1 | Clock-out, high during dead time |

## Verification
On every cycle the assertions check four things: outputs stay low during dead time, overcurrent and force-low remove both outputs immediately, the two outputs never overlap in alternating mode, and the configuration changes only at a period boundary. Other behaviours need the bench's scenarios to show them: exact pulse widths against duty and blanking, the clamp by the soft-start word, the zero-duty floor, the handover between outputs from one period to the next, and the deferred effect of a mid-period change to period, dead time or mode.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;
  typedef enum logic {
    MODE_INPHASE = 1'b0,
    MODE_ALT     = 1'b1
  } steer_mode_e;

  typedef enum logic {
    RAMP_INT = 1'b0,
    RAMP_EXT = 1'b1
  } ramp_src_e;
endpackage

// File: rtl/blpwm_timebase.sv
module blpwm_timebase
  import blpwm_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PER_DEF   = 20,
  parameter int DEAD_DEF  = 3,
  parameter int BLANK_DEF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] blank_i,
  input  steer_mode_e      mode_i,
  input  ramp_src_e        ramp_sel_i,
  output logic             wrap_o,
  output logic             active_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] blank_o,
  output steer_mode_e      mode_o,
  output ramp_src_e        ramp_sel_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, per_q, dead_q, blank_q;
  logic [CNT_W-1:0] per_nxt, dead_nxt;
  steer_mode_e      mode_q;
  ramp_src_e        ramp_q;

  // clamp new config so every period has dead time and an active window
  always_comb begin
    per_nxt = (per_i < TWO) ? TWO : per_i;
    if (dead_i == '0)          dead_nxt = ONE;
    else if (dead_i >= per_nxt) dead_nxt = per_nxt - ONE;
    else                        dead_nxt = dead_i;
  end

  assign wrap_o = (cnt_q == per_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= CNT_W'(PER_DEF);
      dead_q  <= CNT_W'(DEAD_DEF);
      blank_q <= CNT_W'(BLANK_DEF);
      mode_q  <= MODE_INPHASE;
      ramp_q  <= RAMP_INT;
    end else if (wrap_o) begin
      cnt_q   <= '0;
      per_q   <= per_nxt;
      dead_q  <= dead_nxt;
      blank_q <= blank_i;
      mode_q  <= mode_i;
      ramp_q  <= ramp_sel_i;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign active_o   = (cnt_q >= dead_q);
  assign pos_o      = cnt_q - dead_q + ONE;
  assign blank_o    = blank_q;
  assign mode_o     = mode_q;
  assign ramp_sel_o = ramp_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);
  p_dead_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_q != '0) && (dead_q < per_q));
  p_cfg_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(per_q) && $stable(dead_q) && $stable(blank_q) && $stable(mode_q));
endmodule

// File: rtl/blpwm_term.sv
module blpwm_term
  import blpwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int ZERO_FLOOR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] blank_i,
  input  ramp_src_e        ramp_sel_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] ss_clamp_i,
  input  logic [CNT_W-1:0] sense_i,
  input  logic             ilim_i,
  input  logic             oc_i,
  input  logic             force_low_i,
  output logic             en_o
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(ZERO_FLOOR);

  logic [CNT_W-1:0] duty_eff, ramp_val;
  logic             zero_duty, unblanked, soft_hit, kill_set, kill_q;

  assign duty_eff  = (duty_i < ss_clamp_i) ? duty_i : ss_clamp_i;
  assign zero_duty = (duty_eff <= FLOOR);
  assign ramp_val  = (ramp_sel_i == RAMP_EXT) ? sense_i : pos_i;
  assign unblanked = (pos_i >= blank_i);
  assign soft_hit  = unblanked && ((ramp_val >= duty_eff) || ilim_i);
  // hard terminations act immediately and also latch off for the period
  assign kill_set  = active_i && (force_low_i || oc_i || zero_duty || soft_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       kill_q <= 1'b0;
    else if (wrap_i)   kill_q <= 1'b0;
    else if (kill_set) kill_q <= 1'b1;
  end

  assign en_o = active_i && !kill_q && !force_low_i && !oc_i && !zero_duty;

  p_oc_unblanked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |-> !en_o);
  p_no_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !en_o && !wrap_i) |=> !en_o);
endmodule

// File: rtl/blpwm_steer.sv
module blpwm_steer
  import blpwm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wrap_i,
  input  steer_mode_e mode_i,
  input  logic        en_i,
  output logic        out_a_o,
  output logic        out_b_o
);
  logic steer_q; // 0 selects output A

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          steer_q <= 1'b0;
    else if (wrap_i && mode_i == MODE_ALT) steer_q <= !steer_q;
  end

  assign out_a_o = en_i && ((mode_i == MODE_INPHASE) || !steer_q);
  assign out_b_o = en_i && ((mode_i == MODE_INPHASE) ||  steer_q);

  p_alt_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ALT) |-> !(out_a_o && out_b_o));
  p_alt_swap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && mode_i == MODE_ALT) |=> (steer_q != $past(steer_q)));
endmodule

// File: rtl/blanked_pwm.sv
module blanked_pwm
  import blpwm_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int PER_DEF    = 20,
  parameter int DEAD_DEF   = 3,
  parameter int BLANK_DEF  = 2,
  parameter int ZERO_FLOOR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] blank_i,
  input  logic             mode_i,
  input  logic             ramp_sel_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] ss_clamp_i,
  input  logic [CNT_W-1:0] sense_i,
  input  logic             ilim_i,
  input  logic             oc_i,
  input  logic             force_low_i,
  output logic             out_a_o,
  output logic             out_b_o,
  output logic             clk_o
);
  logic             wrap, active, en;
  logic [CNT_W-1:0] pos, blank_q;
  steer_mode_e      mode_q;
  ramp_src_e        ramp_q;

  blpwm_timebase #(
    .CNT_W(CNT_W), .PER_DEF(PER_DEF), .DEAD_DEF(DEAD_DEF), .BLANK_DEF(BLANK_DEF)
  ) u_tb (
    .clk_i, .rst_ni, .per_i, .dead_i, .blank_i,
    .mode_i    (steer_mode_e'(mode_i)),
    .ramp_sel_i(ramp_src_e'(ramp_sel_i)),
    .wrap_o    (wrap),
    .active_o  (active),
    .pos_o     (pos),
    .blank_o   (blank_q),
    .mode_o    (mode_q),
    .ramp_sel_o(ramp_q)
  );

  blpwm_term #(.CNT_W(CNT_W), .ZERO_FLOOR(ZERO_FLOOR)) u_term (
    .clk_i, .rst_ni,
    .wrap_i    (wrap),
    .active_i  (active),
    .pos_i     (pos),
    .blank_i   (blank_q),
    .ramp_sel_i(ramp_q),
    .duty_i, .ss_clamp_i, .sense_i, .ilim_i, .oc_i, .force_low_i,
    .en_o      (en)
  );

  blpwm_steer u_steer (
    .clk_i, .rst_ni,
    .wrap_i (wrap),
    .mode_i (mode_q),
    .en_i   (en),
    .out_a_o, .out_b_o
  );

  assign clk_o = !active;

  p_dead_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o |-> !out_a_o && !out_b_o);
  p_force_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_i |-> !out_a_o && !out_b_o);
  p_start_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_a_o) || $rose(out_b_o)) |-> $fell(clk_o));
endmodule

// File: tb/blanked_pwm_test.sv
module blanked_pwm_test;
  localparam int W = 8;
  localparam int FLOOR = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] per, dead, blank, duty, clamp, sense;
  logic mode, rsel, ilim, oc, frc;
  logic out_a, out_b, clko;

  always #4 clk = !clk;

  blanked_pwm uut (
    .clk_i(clk), .rst_ni(rst_n), .per_i(per), .dead_i(dead), .blank_i(blank),
    .mode_i(mode), .ramp_sel_i(rsel), .duty_i(duty), .ss_clamp_i(clamp),
    .sense_i(sense), .ilim_i(ilim), .oc_i(oc), .force_low_i(frc),
    .out_a_o(out_a), .out_b_o(out_b), .clk_o(clko)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int m_cnt, m_per, m_dead, m_blank, m_mode, m_rsel, m_steer, m_off;

  function automatic int eff_duty();
    return (int'(duty) < int'(clamp)) ? int'(duty) : int'(clamp);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 20; m_dead = 3; m_blank = 2;
      m_mode = 0; m_rsel = 0; m_steer = 0; m_off = 0;
    end else begin
      int pos, rv, d;
      bit act, stop;
      act = m_cnt >= m_dead;
      pos = m_cnt - m_dead + 1;
      d = eff_duty();
      rv = m_rsel ? int'(sense) : pos;
      stop = act && (frc || oc || d <= FLOOR ||
                     (pos >= m_blank && (rv >= d || ilim)));
      if (m_cnt == m_per - 1) begin
        m_cnt = 0; m_off = 0;
        if (m_mode == 1) m_steer = 1 - m_steer;
        m_per = (int'(per) < 2) ? 2 : int'(per);
        if (dead == 0) m_dead = 1;
        else if (int'(dead) >= m_per) m_dead = m_per - 1;
        else m_dead = int'(dead);
        m_blank = int'(blank); m_mode = int'(mode); m_rsel = int'(rsel);
      end else begin
        m_cnt++;
        if (stop) m_off = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit act, en, ea, eb, ec;
      act = m_cnt >= m_dead;
      en = act && !m_off && !frc && !oc && eff_duty() > FLOOR;
      ea = en && (m_mode == 0 || m_steer == 0);
      eb = en && (m_mode == 0 || m_steer == 1);
      ec = !act;
      checks++;
      if (out_a !== ea || out_b !== eb || clko !== ec) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s t=%0t a/b/clk actual %b%b%b expected %b%b%b",
                   tag, $time, out_a, out_b, clko, ea, eb, ec);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_wrap(); // return just after a period boundary
    @(posedge clk);
    while (m_cnt != 0) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    per = 20; dead = 3; blank = 2; duty = 8; clamp = 8'hFF; sense = 0;
    mode = 0; rsel = 0; ilim = 0; oc = 0; frc = 0;
    tag = "R1";
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    tag = "R2/R3/R4"; cyc(60);
    duty = 12; cyc(40);
    duty = 30; tag = "R4 full window"; cyc(40);
    tag = "R9"; duty = 15; clamp = 5; cyc(40); clamp = 8'hFF;
    tag = "R8"; duty = 1; cyc(40); duty = 0; cyc(20);
    tag = "R6"; blank = 6; duty = 2; to_wrap(); cyc(45);
    tag = "R5/R6"; duty = 15; ilim = 1; cyc(40);
    blank = 0; to_wrap(); cyc(40); ilim = 0; blank = 2;
    tag = "R5"; duty = 15; to_wrap(); cyc(6); ilim = 1; cyc(1); ilim = 0; cyc(30);
    tag = "R7"; blank = 10; to_wrap(); cyc(5); oc = 1; cyc(1); oc = 0; cyc(30);
    tag = "R11"; to_wrap(); cyc(6); frc = 1; cyc(2); frc = 0; cyc(30);
    frc = 1; cyc(25); frc = 0; blank = 2;
    tag = "R10"; mode = 1; duty = 9; to_wrap(); cyc(100);
    mode = 0; cyc(45);
    tag = "R12"; to_wrap(); cyc(7); per = 12; dead = 5; mode = 1; cyc(60);
    per = 0; dead = 0; cyc(20); per = 10; dead = 40; cyc(30);
    per = 20; dead = 3; mode = 0; cyc(30);
    tag = "R13"; rsel = 1; duty = 100; to_wrap();
    for (int k = 0; k < 6; k++) begin
      sense = 8'(k * 25); cyc(7);
    end
    sense = 120; cyc(20); sense = 0; cyc(10);
    tag = "R5/R7/R10/R13 mixed";
    for (int k = 0; k < 600; k++) begin
      per = 8'($urandom_range(4, 30)); dead = 8'($urandom_range(0, 8));
      blank = 8'($urandom_range(0, 6)); duty = 8'($urandom_range(0, 25));
      clamp = 8'($urandom_range(0, 40)); sense = 8'($urandom_range(0, 40));
      mode = 1'($urandom_range(0, 1)); rsel = 1'($urandom_range(0, 1));
      ilim = ($urandom_range(0, 9) == 0); oc = ($urandom_range(0, 19) == 0);
      frc = ($urandom_range(0, 29) == 0);
      cyc(1);
    end
    tag = "R1 re-reset";
    rst_n = 1'b0; cyc(3); rst_n = 1'b1;
    per = 20; dead = 3; blank = 2; duty = 8; clamp = 8'hFF;
    mode = 0; rsel = 0; ilim = 0; oc = 0; frc = 0;
    cyc(30);
    finish_run();
  end
endmodule